// File: doc/BRIEF.md
# Real-Time Clock Minute Core with Seconds Rounding and Interrupt Control

This block keeps the seconds and minutes of a real-time clock. It advances on a one-per-second tick and also watches a sixteen-per-second tick and a single alarm-match input. Software drives it through a byte-wide register bus with two registers. The control register holds the enables, the interrupt masks and a page selector. The command register takes write-only strobes that clear the time, clear the alarm logic, or round the seconds to the nearest whole minute.

Every command written to the command register goes through a small sequencer with the states IDLE, ADJ, CLKRST, ALMRST and BOTHRST. A write that asks for both resets moves to BOTHRST. A write that asks for a clock reset moves to CLKRST, and this takes precedence over a rounding request. A write that asks for an alarm reset alone moves to ALMRST. A rounding request, accepted only while page 0 is selected, moves to ADJ. Any other write, or no write, leads to IDLE. Each of these transitions can be taken from any state. Each non-IDLE state lasts one system clock and drives its strobe for that cycle.

The interrupt request is a one-cycle pulse. It appears in the cycle after an enabled event: a one-second tick, a sixteen-per-second tick or an alarm match, gated by the global interrupt enable.

Top module: `rtc_adj_core`

## Requirements
- R1: After reset the control register reads 0x00, seconds and minutes are 0, and irq and all three strobes are low.
- R2: The control register is at address 0 and keeps bit 7 (1 Hz mask, 1 = masked), bit 6 (16 Hz mask, 1 = masked), bit 3 (clock enable), bit 2 (alarm enable), bit 1 (interrupt enable) and bit 0 (page, 1 = page 1). Bits 5 and 4 read 0. The command register at address 1 always reads 0x00.
- R3: When the clock-enable bit is 1, each 1 Hz tick increments seconds. Seconds go from 59 to 0 and carry into minutes, and minutes go from 59 to 0. When clock enable is 0, ticks leave the time unchanged.
- R4: Writing 1 to bit 0 of the command register with seconds 0 to 29 sets seconds to 0 and leaves minutes unchanged.
- R5: The same command with seconds 30 to 59 sets seconds to 0 and increments minutes, with 59 going to 0.
- R6: The rounding strobe adj_strobe is high for exactly one clock, in the cycle after the write, and the time changes at the end of that cycle.
- R7: Writing 1 to bit 5 of the command register clears seconds and minutes, with clk_rst_strobe high for one clock. Writing 1 to bit 4 raises alm_rst_strobe for one clock and leaves the time unchanged. A write with bits 5, 4 and 0 all 0 does nothing. Bit 5 overrides bit 0 in the same write.
- R8: irq pulses for one clock in the cycle after any of these events while interrupt enable is 1: a 1 Hz tick with bit 7 = 0, a 16 Hz tick with bit 6 = 0, or alarm_match with alarm enable = 1. Masked sources, or interrupt enable = 0, give no pulse.
- R9: When a 1 Hz tick falls in the rounding cycle, the tick is applied first and the result is then rounded. For example, 0:29 becomes 1:00.
- R10: While the page bit is 1, a rounding command is ignored: there is no strobe and the time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| tick_16hz | input | 1 | One-cycle pulse, sixteen per second |
| alarm_match | input | 1 | Alarm comparison hit |
| wr_en | input | 1 | Register write strobe (full byte) |
| addr | input | 1 | Register address: 0 control, 1 command |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| sec_o | output | 6 | Seconds, 0 to 59 |
| min_o | output | 6 | Minutes, 0 to 59 |
| irq | output | 1 | Interrupt request pulse |
| adj_strobe | output | 1 | Rounding command active |
| clk_rst_strobe | output | 1 | Clock reset active |
| alm_rst_strobe | output | 1 | Alarm reset request |

## Verification
The rounding cycle and a one-second tick can coincide. The bench provokes this by writing the rounding command in one cycle and pulsing tick_1hz in the next, which is the cycle in which adj_strobe is high. At 0:29 this must give 1:00, because the tick carries seconds to 30 before rounding. Applying the tick after the rounding would give 0:01 instead. A second collision, a clock reset and a rounding request in the same write, is judged by the time reading 0:00 with no rounding strobe.

// File: rtl/rtc_adj_pkg.sv
package rtc_adj_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADJ,
        ST_CLKRST,
        ST_ALMRST,
        ST_BOTHRST
    } cmd_state_t;

    // control register field positions
    localparam int B_MASK1 = 7;
    localparam int B_MASK16 = 6;
    localparam int B_CLKEN = 3;
    localparam int B_ALMEN = 2;
    localparam int B_IRQEN = 1;
    localparam int B_PAGE = 0;

    // command register strobe positions
    localparam int B_CLKRST = 5;
    localparam int B_ALMRST = 4;
    localparam int B_ADJ = 0;

    localparam logic [7:0] CTRL_KEEP = 8'hCF;

endpackage

// File: rtl/rtc_regfile.sv
module rtc_regfile
    import rtc_adj_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              mask1,
    output logic              mask16,
    output logic              clk_en,
    output logic              alm_en,
    output logic              irq_en,
    output logic              page
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(CTRL_KEEP);

    logic [DATA_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && addr == CTRL_ADDR) begin
            ctrl_q <= wdata & KEEP;
        end
    end

    always_comb begin
        rdata = (addr == CTRL_ADDR) ? ctrl_q : '0;
    end

    assign mask1  = ctrl_q[B_MASK1];
    assign mask16 = ctrl_q[B_MASK16];
    assign clk_en = ctrl_q[B_CLKEN];
    assign alm_en = ctrl_q[B_ALMEN];
    assign irq_en = ctrl_q[B_IRQEN];
    assign page   = ctrl_q[B_PAGE];
endmodule

// File: rtl/rtc_cmd_fsm.sv
module rtc_cmd_fsm
    import rtc_adj_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              page,
    output logic              adj,
    output logic              clk_rst,
    output logic              alm_rst
);
    cmd_state_t state_q, state_d;

    // next state: every transition may be taken from any state
    always_comb begin
        state_d = ST_IDLE;
        if (cmd_wr) begin
            unique case ({wdata[B_CLKRST], wdata[B_ALMRST]})
                2'b11: state_d = ST_BOTHRST;
                2'b10: state_d = ST_CLKRST;
                2'b01: state_d = ST_ALMRST;
                default: state_d = (wdata[B_ADJ] && !page) ? ST_ADJ : ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        adj     = 1'b0;
        clk_rst = 1'b0;
        alm_rst = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_ADJ:     adj = 1'b1;
            ST_CLKRST:  clk_rst = 1'b1;
            ST_ALMRST:  alm_rst = 1'b1;
            ST_BOTHRST: begin
                clk_rst = 1'b1;
                alm_rst = 1'b1;
            end
            default:    ;
        endcase
    end
endmodule

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt #(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int CNT_W = $clog2((SEC_MOD > MIN_MOD) ? SEC_MOD : MIN_MOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             adj,
    input  logic             clr,
    output logic [CNT_W-1:0] sec,
    output logic [CNT_W-1:0] min
);
    localparam logic [CNT_W-1:0] SEC_LAST = CNT_W'(SEC_MOD - 1);
    localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_MOD - 1);
    localparam logic [CNT_W-1:0] HALF     = CNT_W'(SEC_MOD / 2);

    logic [CNT_W-1:0] sec_t, min_t, sec_d, min_d;

    // stage 1: tick advance
    always_comb begin
        sec_t = sec;
        min_t = min;
        if (step) begin
            if (sec == SEC_LAST) begin
                sec_t = '0;
                min_t = (min == MIN_LAST) ? '0 : min + 1'b1;
            end else begin
                sec_t = sec + 1'b1;
            end
        end
    end

    // stage 2: rounding to the nearest minute on the ticked value
    always_comb begin
        sec_d = sec_t;
        min_d = min_t;
        if (adj) begin
            sec_d = '0;
            if (sec_t >= HALF) min_d = (min_t == MIN_LAST) ? '0 : min_t + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec <= '0;
            min <= '0;
        end else if (clr) begin
            sec <= '0;
            min <= '0;
        end else begin
            sec <= sec_d;
            min <= min_d;
        end
    end
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1hz,
    input  logic tick_16hz,
    input  logic alarm_match,
    input  logic mask1,
    input  logic mask16,
    input  logic alm_en,
    input  logic irq_en,
    output logic irq
);
    logic any_src;

    always_comb begin
        any_src = (tick_1hz && !mask1) || (tick_16hz && !mask16) || (alarm_match && alm_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_en && any_src;
    end
endmodule

// File: rtl/rtc_adj_core.sv
module rtc_adj_core #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 1,
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int CNT_W = $clog2((SEC_MOD > MIN_MOD) ? SEC_MOD : MIN_MOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              tick_16hz,
    input  logic              alarm_match,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  sec_o,
    output logic [CNT_W-1:0]  min_o,
    output logic              irq,
    output logic              adj_strobe,
    output logic              clk_rst_strobe,
    output logic              alm_rst_strobe
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(1);

    logic mask1, mask16, clk_en, alm_en, irq_en, page;
    logic cmd_wr;

    assign cmd_wr = wr_en && (addr == CMD_ADDR);

    rtc_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .mask1(mask1), .mask16(mask16), .clk_en(clk_en),
        .alm_en(alm_en), .irq_en(irq_en), .page(page)
    );

    rtc_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(wdata), .page(page),
        .adj(adj_strobe), .clk_rst(clk_rst_strobe), .alm_rst(alm_rst_strobe)
    );

    rtc_time_cnt #(.SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(tick_1hz && clk_en), .adj(adj_strobe),
        .clr(clk_rst_strobe), .sec(sec_o), .min(min_o)
    );

    rtc_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_16hz(tick_16hz),
        .alarm_match(alarm_match), .mask1(mask1), .mask16(mask16),
        .alm_en(alm_en), .irq_en(irq_en), .irq(irq)
    );
endmodule

// File: rtl/rtc_adj_chk.sv
module rtc_adj_chk #(
    parameter int SEC_MOD = 60,
    parameter int MIN_MOD = 60,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1hz,
    input logic             clk_en,
    input logic             irq_en,
    input logic             cmd_wr,
    input logic             adj_strobe,
    input logic             clk_rst_strobe,
    input logic             alm_rst_strobe,
    input logic             irq,
    input logic [CNT_W-1:0] sec_o,
    input logic [CNT_W-1:0] min_o
);
    localparam logic [CNT_W-1:0] SEC_LAST = CNT_W'(SEC_MOD - 1);
    localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_MOD - 1);
    localparam logic [CNT_W-1:0] HALF     = CNT_W'(SEC_MOD / 2);

    logic plain_adj;
    assign plain_adj = adj_strobe && !clk_rst_strobe && !(tick_1hz && clk_en);

    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sec_o <= SEC_LAST && min_o <= MIN_LAST);

    a_r4_round_down: assert property (@(posedge clk) disable iff (!rst_n)
        plain_adj && sec_o < HALF |=> sec_o == '0 && $stable(min_o));

    a_r5_round_up: assert property (@(posedge clk) disable iff (!rst_n)
        plain_adj && sec_o >= HALF |=> sec_o == '0 &&
        min_o == (($past(min_o) == MIN_LAST) ? '0 : $past(min_o) + 1'b1));

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        adj_strobe && !cmd_wr |=> !adj_strobe);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clk_rst_strobe |=> sec_o == '0 && min_o == '0);

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(adj_strobe && (clk_rst_strobe || alm_rst_strobe)));

    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq);
endmodule

bind rtc_adj_core rtc_adj_chk #(.SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .clk_en(clk_en), .irq_en(irq_en),
    .cmd_wr(cmd_wr), .adj_strobe(adj_strobe), .clk_rst_strobe(clk_rst_strobe),
    .alm_rst_strobe(alm_rst_strobe), .irq(irq), .sec_o(sec_o), .min_o(min_o)
);

// File: tb/rtc_adj_core_tb.sv
module rtc_adj_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0, tick_16hz = 1'b0, alarm_match = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [5:0] sec_o, min_o;
    logic       irq, adj_strobe, clk_rst_strobe, alm_rst_strobe;

    int checks = 0;
    int errors = 0;
    int exp_s = 0;
    int exp_m = 0;

    rtc_adj_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .tick_16hz(tick_16hz),
        .alarm_match(alarm_match), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sec_o(sec_o), .min_o(min_o), .irq(irq),
        .adj_strobe(adj_strobe), .clk_rst_strobe(clk_rst_strobe),
        .alm_rst_strobe(alm_rst_strobe)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_time(string req);
        chk({req, " sec"}, int'(sec_o), exp_s);
        chk({req, " min"}, int'(min_o), exp_m);
    endtask

    // drive a write at a falling edge; returns one cycle later (register updated)
    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00; addr = 1'b0;
    endtask

    task automatic rd(input logic a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
        addr = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick_1hz = 1'b1;
            @(negedge clk);
            tick_1hz = 1'b0;
            exp_s++;
            if (exp_s == 60) begin
                exp_s = 0;
                exp_m = (exp_m + 1) % 60;
            end
        end
    endtask

    task automatic t_reset();
        int v;
        rd(1'b0, v);
        chk("R1 ctrl", v, 0);
        chk_time("R1");
        chk("R1 irq", int'(irq), 0);
        chk("R1 strobes", int'({adj_strobe, clk_rst_strobe, alm_rst_strobe}), 0);
    endtask

    task automatic t_regs();
        int v;
        wr(1'b0, 8'hFF);
        rd(1'b0, v);
        chk("R2 ctrl keep", v, 8'hCF);
        rd(1'b1, v);
        chk("R2 cmd reads 0", v, 0);
        wr(1'b0, 8'h00);
        rd(1'b0, v);
        chk("R2 ctrl cleared", v, 0);
        chk("R2 no strobe", int'(adj_strobe), 0);
    endtask

    task automatic t_count();
        ticks(3);
        exp_s = 0;  // clock disabled: the model must not move
        chk_time("R3 disabled");
        wr(1'b0, 8'h08);
        ticks(3);
        chk_time("R3 counting");
    endtask

    task automatic t_adjust(string req);
        wr(1'b1, 8'h01);
        chk({req, " R6 strobe on"}, int'(adj_strobe), 1);
        @(negedge clk);
        chk({req, " R6 strobe off"}, int'(adj_strobe), 0);
        if (exp_s >= 30) exp_m = (exp_m + 1) % 60;
        exp_s = 0;
        chk_time(req);
    endtask

    task automatic t_wrap();
        ticks(59 * 60 + 59 - (exp_m * 60 + exp_s));
        chk_time("R3 at 59:59");
        ticks(1);
        chk_time("R3 wrap to 0:00");
        ticks(59 * 60 + 45);
        t_adjust("R5 wrap");
    endtask

    task automatic t_page1();
        wr(1'b0, 8'h09);
        ticks(40);
        wr(1'b1, 8'h01);
        chk("R10 no strobe", int'(adj_strobe), 0);
        @(negedge clk);
        chk_time("R10 unchanged");
        wr(1'b0, 8'h08);
    endtask

    task automatic t_collide();
        wr(1'b1, 8'h20);
        @(negedge clk);
        exp_s = 0; exp_m = 0;
        ticks(29);
        addr = 1'b1; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00; addr = 1'b0;
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        exp_s = 0; exp_m = 1;
        chk_time("R9 tick then round");
    endtask

    task automatic t_resets();
        ticks(7);
        wr(1'b1, 8'h20);
        chk("R7 clk strobe", int'(clk_rst_strobe), 1);
        @(negedge clk);
        exp_s = 0; exp_m = 0;
        chk_time("R7 cleared");
        chk("R7 clk strobe off", int'(clk_rst_strobe), 0);
        ticks(5);
        wr(1'b1, 8'h10);
        chk("R7 alm strobe", int'(alm_rst_strobe), 1);
        @(negedge clk);
        chk("R7 alm strobe off", int'(alm_rst_strobe), 0);
        chk_time("R7 alarm reset keeps time");
        wr(1'b1, 8'h00);
        chk("R7 zero write", int'({adj_strobe, clk_rst_strobe, alm_rst_strobe}), 0);
        @(negedge clk);
        chk_time("R7 zero write time");
        ticks(40);
        wr(1'b1, 8'h21);
        chk("R7 priority no adj", int'(adj_strobe), 0);
        @(negedge clk);
        exp_s = 0; exp_m = 0;
        chk_time("R7 priority");
    endtask

    task automatic pulse_irq(string req, int which, int exp);
        if (which == 0) tick_1hz = 1'b1;
        if (which == 1) tick_16hz = 1'b1;
        if (which == 2) alarm_match = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0; tick_16hz = 1'b0; alarm_match = 1'b0;
        chk(req, int'(irq), exp);
        @(negedge clk);
        chk({req, " one cycle"}, int'(irq), 0);
    endtask

    task automatic t_irq();
        wr(1'b0, 8'h02);  // irq enable, both ticks unmasked, clock stopped
        pulse_irq("R8 16hz", 1, 1);
        pulse_irq("R8 1hz", 0, 1);
        pulse_irq("R8 alarm disabled", 2, 0);
        wr(1'b0, 8'h42);
        pulse_irq("R8 16hz masked", 1, 0);
        wr(1'b0, 8'h86);
        pulse_irq("R8 1hz masked", 0, 0);
        pulse_irq("R8 alarm", 2, 1);
        wr(1'b0, 8'h04);
        pulse_irq("R8 global off", 2, 0);
        pulse_irq("R8 global off 16hz", 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_count();
        t_adjust("R4");
        ticks(45);
        t_adjust("R5");
        t_wrap();
        t_page1();
        t_collide();
        t_resets();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1500000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule